// File: doc/BRIEF.md
# Right-Justified Serial Audio DAC Feeder

This block feeds an external audio codec with 16-bit stereo samples over a three-wire serial audio link. The codec owns both link clocks: it drives the bit clock and the frame clock. The block receives both as ordinary inputs and samples them with its own, much faster system clock. Each sample word comes from an upstream FIFO reader as 32 bits, with its bytes in storage order. The block turns each word into two channel samples, most significant byte first. It then shifts them out on the serial data line in right-justified form, within two 32-bit slots per frame.

The block asks for a word once per frame, in the middle of the frame. The word that comes back is then held until the next frame begins. If no word has arrived when a frame begins, the frame is sent as silence. The control is a three-state machine:
- `S_WAIT`: after reset, the block waits for the first frame-clock rise.
- `S_LEFT`: the left slot is in progress.
- `S_RIGHT`: the right slot is in progress.

The transitions are these. `S_WAIT` goes to `S_LEFT` on a frame start. `S_LEFT` goes to `S_RIGHT` on the 33rd bit-clock fall of the frame, which also fires the request. `S_RIGHT` goes to `S_LEFT` on the next frame start, and a frame start seen in `S_LEFT` restarts `S_LEFT`. Reset returns the machine to `S_WAIT` from any state.

Top module: `dac_rj_serializer`

## Requirements
- R1: While `rst_n` is low at a rising `clk` edge, `sdata` and `word_req` are 0 from that edge on.
- R2: After reset, until the first frame start, `sdata` stays 0 and `word_req` never pulses. A frame start is the first bit-clock fall on or after a frame-clock rise.
- R3: The first byte received occupies `word_in[31:24]` and holds the left low byte. `[23:16]` holds the left high byte, `[15:8]` the right low byte and `[7:0]` the right high byte. The left sample is therefore {`word_in[23:16]`, `word_in[31:24]`} and the right sample is {`word_in[7:0]`, `word_in[15:8]`}.
- R4: Bit positions 0 to 63 of a frame are counted on bit-clock falls, and position 0 is the frame start. Positions 0–15 carry 0 and positions 16–31 carry the left sample, MSB first. Positions 32–47 carry 0 and positions 48–63 carry the right sample, MSB first.
- R5: `sdata` takes the value of position p exactly 3 `clk` rising edges after the bit-clock fall of position p is applied. It does not change at any other time.
- R6: `word_req` is a one-cycle pulse. It rises 3 `clk` edges after the fall at position 32, once per frame.
- R7: A frame that starts with no word held since the previous frame start is all zeros. A word is used by one frame only.
- R8: A word offered with `word_vld` high for one cycle is held and used by the next frame start.
- R9: A reset in mid-frame discards the held word and returns the block to `S_WAIT`. Until the next frame start, `sdata` is 0 and no request is made. The first frame after that is silent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bclk_in | input | 1 | Bit clock from the codec |
| lrclk_in | input | 1 | Frame clock from the codec; high for the left slot |
| word_in | input | 32 | Stereo sample word in storage byte order |
| word_vld | input | 1 | One-cycle strobe marking `word_in` as valid |
| word_req | output | 1 | One-cycle request for the next sample word |
| sdata | output | 1 | Serial data to the codec |

## Verification
A wrong slot counter or state moves the request pulse away from three cycles after the 33rd fall. It also shifts sample bits into the padding positions. Either fault shows within one frame of 64 bit clocks. A bad byte swap or a wrong pad length corrupts the first data bit of the next loaded frame, at position 16. A held-word flag that is not cleared resends an old sample in a frame that should be silent. The bench predicts every output on every system clock, so any of these faults shows as a mismatch in the cycle where it happens.

// File: rtl/dac_pkg.sv
package dac_pkg;
    typedef enum logic [1:0] {
        S_WAIT  = 2'd0,
        S_LEFT  = 2'd1,
        S_RIGHT = 2'd2
    } ser_state_t;
    localparam int BYTE_W = 8;
endpackage

// File: rtl/dac_edge_sync.sv
module dac_edge_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b0,
    parameter bit RISE      = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic pulse_o
);
    logic [STAGES:0] pipe;

    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= {(STAGES+1){RESET_VAL}};
        else        pipe <= {pipe[STAGES-1:0], din};
    end

    generate
        if (RISE) begin : g_rise
            assign pulse_o = pipe[STAGES-1] & ~pipe[STAGES];
        end else begin : g_fall
            assign pulse_o = ~pipe[STAGES-1] & pipe[STAGES];
        end
    endgenerate
endmodule

// File: rtl/dac_byte_swap.sv
module dac_byte_swap
    import dac_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int NB = W / BYTE_W;

    generate
        for (genvar b = 0; b < NB; b++) begin : g_byte
            assign dout[BYTE_W*b +: BYTE_W] = din[W-BYTE_W-BYTE_W*b +: BYTE_W];
        end
    endgenerate
endmodule

// File: rtl/dac_rj_serializer.sv
module dac_rj_serializer
    import dac_pkg::*;
#(
    parameter int SAMPLE_W    = 16,
    parameter int SLOT_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bclk_in,
    input  logic                  lrclk_in,
    input  logic [2*SAMPLE_W-1:0] word_in,
    input  logic                  word_vld,
    output logic                  word_req,
    output logic                  sdata
);
    localparam int WORD_W  = 2 * SAMPLE_W;
    localparam int FRAME_W = 2 * SLOT_W;
    localparam int PAD_W   = SLOT_W - SAMPLE_W;
    localparam int CNT_W   = $clog2(SLOT_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOT_W - 1);

    logic bfall, lrise, pend, start;
    ser_state_t state, nstate;
    logic [CNT_W-1:0]   cnt;
    logic [FRAME_W-1:0] frame_sr, next_frame;
    logic [WORD_W-1:0]  hold;
    logic               hold_vld;
    logic [SAMPLE_W-1:0] left_s, right_s;
    logic sdata_q, req_q;

    dac_edge_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0), .RISE(1'b0)) u_bclk (
        .clk(clk), .rst_n(rst_n), .din(bclk_in), .pulse_o(bfall)
    );
    dac_edge_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1), .RISE(1'b1)) u_lrclk (
        .clk(clk), .rst_n(rst_n), .din(lrclk_in), .pulse_o(lrise)
    );

    dac_byte_swap #(.W(SAMPLE_W)) u_swap_l (.din(hold[WORD_W-1 -: SAMPLE_W]), .dout(left_s));
    dac_byte_swap #(.W(SAMPLE_W)) u_swap_r (.din(hold[SAMPLE_W-1:0]),         .dout(right_s));

    // A frame-clock rise waits for the next bit-clock fall
    always_ff @(posedge clk) begin
        if (!rst_n)     pend <= 1'b0;
        else if (bfall) pend <= 1'b0;
        else if (lrise) pend <= 1'b1;
    end

    assign start = bfall & (lrise | pend);

    // Word holding register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold     <= '0;
            hold_vld <= 1'b0;
        end else if (word_vld) begin
            hold     <= word_in;
            hold_vld <= 1'b1;
        end else if (start) begin
            hold_vld <= 1'b0;
        end
    end

    assign next_frame = hold_vld ? {{PAD_W{1'b0}}, left_s, {PAD_W{1'b0}}, right_s}
                                 : '0;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_WAIT;
        else        state <= nstate;
    end

    always_comb begin
        nstate = state;
        unique case (state)
            S_WAIT:  if (start) nstate = S_LEFT;
            S_LEFT: begin
                if (start)                    nstate = S_LEFT;
                else if (bfall && cnt == LAST) nstate = S_RIGHT;
            end
            S_RIGHT: if (start) nstate = S_LEFT;
            default: nstate = S_WAIT;
        endcase
    end

    // Outputs and shift path
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdata_q  <= 1'b0;
            req_q    <= 1'b0;
            frame_sr <= '0;
            cnt      <= '0;
        end else begin
            req_q <= (state == S_LEFT) && bfall && !start && (cnt == LAST);
            if (start) begin
                sdata_q  <= next_frame[FRAME_W-1];
                frame_sr <= {next_frame[FRAME_W-2:0], 1'b0};
                cnt      <= '0;
            end else if (bfall) begin
                sdata_q  <= frame_sr[FRAME_W-1];
                frame_sr <= {frame_sr[FRAME_W-2:0], 1'b0};
                if (state == S_LEFT) cnt <= cnt + 1'b1;
            end
        end
    end

    assign sdata    = sdata_q;
    assign word_req = req_q;

    AST_SD_ONLY_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdata_q) |-> $past(bfall)); // R5
    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |=> !req_q); // R6
    AST_REQ_IN_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |-> (state == S_RIGHT)); // R6
    AST_WAIT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT) |-> (!sdata_q && !req_q)); // R2
    AST_HOLD_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !word_vld) |=> !hold_vld); // R7
    AST_START_TO_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (state == S_LEFT)); // R4
endmodule

// File: tb/sim_dac_rj_serializer.sv
module sim_dac_rj_serializer;
    logic clk = 1'b0;
    logic rst_n, bclk_in, lrclk_in, word_vld;
    logic [31:0] word_in;
    logic word_req, sdata;

    always #5 clk = ~clk;

    dac_rj_serializer u0 (
        .clk(clk), .rst_n(rst_n), .bclk_in(bclk_in), .lrclk_in(lrclk_in),
        .word_in(word_in), .word_vld(word_vld), .word_req(word_req), .sdata(sdata)
    );

    typedef struct { int t; logic sd; logic rq; } ev_t;
    ev_t q[$];

    int checks = 0, fails = 0, now = 0, vld_at = -1, widx = 0, n_req = 0;
    bit done = 0, resp_en = 1, started = 0, m_hold_v = 0, m_lr_prev = 1;
    logic exp_sd = 0, exp_rq = 0;
    logic [31:0] m_hold;
    logic [63:0] m_frame = '0;
    logic [31:0] words [8];
    string cur_req = "R1";

    function automatic logic [63:0] build(input logic [31:0] w);
        logic [15:0] l, r;
        l = {w[23:16], w[31:24]};
        r = {w[7:0], w[15:8]};
        return {16'h0, l, 16'h0, r};
    endfunction

    task automatic check(input string what, input logic act, input logic expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s %s at cycle %0d: got %b expected %b", cur_req, what, now, act, expv);
        end
    endtask

    task automatic tick();
        ev_t e;
        @(negedge clk);
        now++;
        while (q.size() > 0 && q[0].t <= now) begin
            e = q.pop_front();
            exp_sd = e.sd;
            exp_rq = e.rq;
        end
        check("sdata", sdata, exp_sd);
        check("word_req", word_req, exp_rq);
        if (word_req === 1'b1) begin
            n_req++;
            if (resp_en && widx < 8) vld_at = now + 5;
        end
        if (now == vld_at) begin
            word_vld = 1'b1;
            word_in  = words[widx];
            m_hold   = words[widx];
            m_hold_v = 1'b1;
            widx++;
        end else begin
            word_vld = 1'b0;
        end
    endtask

    task automatic model_fall(input int pos);
        ev_t e;
        logic sd;
        if (lrclk_in && !m_lr_prev) begin
            started = 1'b1;
            m_frame = m_hold_v ? build(m_hold) : 64'h0;
            m_hold_v = 1'b0;
        end
        m_lr_prev = lrclk_in;
        sd = started ? m_frame[63-pos] : 1'b0;
        e.t = now + 3; e.sd = sd; e.rq = started && (pos == 32);
        q.push_back(e);
        e.t = now + 4; e.rq = 1'b0;
        q.push_back(e);
    endtask

    task automatic reset_pulse();
        cur_req  = "R9";
        rst_n    = 1'b0;
        q.delete();
        exp_sd   = 1'b0;
        exp_rq   = 1'b0;
        started  = 1'b0;
        m_hold_v = 1'b0;
        vld_at   = -1;
        repeat (4) tick();
        rst_n = 1'b1;
        repeat (4) tick();
    endtask

    task automatic bit_cycle(input int pos, input bit rst_here);
        bclk_in  = 1'b0;
        lrclk_in = (pos < 32);
        model_fall(pos);
        repeat (8) tick();
        bclk_in = 1'b1;
        repeat (8) tick();
        if (rst_here) reset_pulse();
    endtask

    initial begin
        words[0] = 32'h34A5_7E81;
        words[1] = 32'hFFFF_0000;
        words[2] = 32'h0180_8001;
        words[3] = 32'h5AC3_3CA5;
        words[4] = 32'hDEAD_BEEF;
        words[5] = 32'h0102_0304;
        words[6] = 32'h8000_0080;
        words[7] = 32'hC001_F00D;
        rst_n = 1'b0; bclk_in = 1'b1; lrclk_in = 1'b0;
        word_vld = 1'b0; word_in = '0;
        cur_req = "R1";
        repeat (6) tick();
        rst_n = 1'b1;
        cur_req = "R2";
        for (int p = 40; p < 64; p++) bit_cycle(p, 1'b0);
        for (int f = 0; f < 9; f++) begin
            case (f)
                0:       cur_req = "R4 R7";
                4:       cur_req = "R7";
                7:       cur_req = "R9 R7";
                default: cur_req = "R3 R4 R5 R6 R8";
            endcase
            resp_en = (f != 3);
            for (int p = 0; p < 64; p++) bit_cycle(p, (f == 6) && (p == 40));
        end
        repeat (8) tick();
        cur_req = "R6";
        checks++;
        if (n_req != 9) begin
            fails++;
            $display("FAIL R6 request count: got %0d expected %0d", n_req, 9);
        end
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired at cycle %0d", now);
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end
endmodule